// File: doc/BRIEF.md
# CAN Bit Timer with Edge Resynchronization

This block turns a system clock into CAN bit timing. A prescaler divides the clock into time quanta of `2 * (presc + 1)` clock periods. Each bit is built from quanta: one synchronization quantum, then a first timing span (propagation plus phase 1), then phase 2. The receive line is sampled once per bit at the end of the first span. A sample strobe marks each sample and a bit-start strobe marks the first quantum of each bit.

The receive line passes through a two-flop synchronizer. Recessive-to-dominant transitions are then used to keep the local bit grid aligned with other nodes. While `hard_sync_en` is high (bus idle or start of frame), a falling edge restarts the bit at once. Otherwise the block resynchronizes once per bit. A late edge lengthens phase 1. An early edge shortens phase 2 or ends the bit. Both corrections are limited to the programmed jump width. An illegal timing configuration raises `cfg_err` and holds the timer in a halt state.

The controller has four states:
- `ST_HALT` is the configuration-error state.
- `ST_SYNC` is the one-quantum synchronization segment.
- `ST_SEG1` covers propagation plus phase 1, including any extension.
- `ST_SEG2` is phase 2, less any cut.

Its transitions are:
- HALT→SYNC when the configuration becomes legal.
- SYNC→SEG1 on a quantum tick.
- SEG1→SEG2 on the tick that ends the extended span; this tick takes the sample.
- SEG2→SYNC on the tick that ends the shortened span.
- A restart to SYNC from any running state, caused by a hard sync or by an early edge within the jump width.
- Any state→HALT on a configuration error.

Top module: `cbt_bit_timer`

## Requirements
- R1: A quantum lasts 2*(presc+1) clock cycles. With no synchronizing edges, consecutive `bit_start` pulses are (1+prop+ph1+ph2) quanta apart.
- R2: `sample_strobe` pulses (1+prop+ph1+ext) quanta after `bit_start`, where ext is the current phase-1 extension (0 with no edge). At that moment `rx_bit` takes the synchronized RX level (1 = recessive, 0 = dominant). `rx_bit` changes at no other time, and the two strobes never coincide.
- R3: The configuration is legal when all of the following hold: prop, ph1 and ph2 each lie in 1..8; sjw lies in 1..4; prop+ph1 >= ph2; and ph2 >= sjw. Otherwise `cfg_err` is 1 and both strobes stay low. In the cycle after the configuration becomes legal again, `bit_start` pulses.
- R4: A falling edge seen in quantum q of the first span (q = 1 for its first quantum) lengthens that span by min(q, sjw) quanta. This also moves the sample point.
- R5: A falling edge in phase 2, seen when k phase-2 quanta have already elapsed, has one of two effects. If k+sjw >= ph2, a new bit starts immediately. Otherwise phase 2 is cut by sjw quanta.
- R6: A falling edge inside the synchronization quantum causes no resynchronization.
- R7: At most one resynchronization happens per bit. Later edges in the same bit have no effect.
- R8: Dominant-to-recessive (0→1) transitions never synchronize.
- R9: With `hard_sync_en` high, a falling edge on RX restarts the bit with no jump-width limit. The bit restarts 3 clock cycles after the RX change, and `bit_start` is visible in the following half cycle.
- R10: During and right after reset, the strobes and `cfg_err` (for a legal configuration) are 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx | input | 1 | CAN receive line, asynchronous |
| presc | input | 6 | Prescaler value; quantum = 2*(presc+1) clocks |
| seg_prop | input | 4 | Propagation segment length in quanta |
| seg_ph1 | input | 4 | Phase segment 1 length in quanta |
| seg_ph2 | input | 4 | Phase segment 2 length in quanta |
| sjw | input | 3 | Synchronization jump width in quanta |
| hard_sync_en | input | 1 | Falling edges perform hard synchronization |
| rx_bit | output | 1 | Bit value taken at the last sample point |
| sample_strobe | output | 1 | One-cycle pulse when `rx_bit` is updated |
| bit_start | output | 1 | One-cycle pulse in the first cycle of each bit |
| cfg_err | output | 1 | Timing configuration is illegal |

## Verification
Both strobes are registered. Each appears in the clock cycle after the quantum tick that ends a segment, so all bit and sample timing is measured in whole clock cycles counted from a `bit_start` pulse. An RX change takes three clock edges to act: two synchronizer stages and the edge detector. The bench therefore changes RX just after a quantum boundary so that the edge falls in a known quantum, and it derives the expected bit length from the requirement formulas. `cfg_err` is combinational from the inputs and is read half a cycle after a change, while the restart pulse after recovery is read one cycle later. All outputs are sampled on the falling clock edge.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_SYNC = 2'd1,
        ST_SEG1 = 2'd2,
        ST_SEG2 = 2'd3
    } bt_state_e;

endpackage

// File: rtl/cbt_quantum_gen.sv
`timescale 1ns/1ps
module cbt_quantum_gen #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               restart_i,
    output logic               tick_o
);
    localparam int CNT_W = PRESC_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // one quantum spans 2*(presc+1) cycles: count 0 .. 2*presc+1
    assign limit  = {presc_i, 1'b1};
    assign tick_o = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R1

endmodule

// File: rtl/cbt_rx_edge.sv
`timescale 1ns/1ps
module cbt_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], rx_i};
        end
    end

    assign rx_s_o = sh_q[STAGES-1];
    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R8

endmodule

// File: rtl/cbt_cfg_check.sv
`timescale 1ns/1ps
module cbt_cfg_check #(
    parameter int SEG_W   = 4,
    parameter int SJW_W   = 3,
    parameter int SEG_MAX = 8,
    parameter int SJW_MAX = 4
) (
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SJW_W-1:0] sjw_i,
    output logic             err_o
);
    localparam int NSEG = 3;

    logic [SEG_W-1:0] segs [NSEG];
    logic [NSEG-1:0]  seg_bad;
    logic [SEG_W:0]   span1;
    logic             sjw_bad;

    assign segs[0] = prop_i;
    assign segs[1] = ph1_i;
    assign segs[2] = ph2_i;

    for (genvar g = 0; g < NSEG; g++) begin : g_range
        assign seg_bad[g] = (segs[g] == '0) || (segs[g] > SEG_W'(SEG_MAX));
    end

    assign sjw_bad = (sjw_i == '0) || (sjw_i > SJW_W'(SJW_MAX));
    assign span1   = {1'b0, prop_i} + {1'b0, ph1_i};

    assign err_o = (|seg_bad) || sjw_bad
                || (span1 < {1'b0, ph2_i})
                || (ph2_i < SEG_W'(sjw_i));

endmodule

// File: rtl/cbt_bit_timer.sv
`timescale 1ns/1ps
module cbt_bit_timer #(
    parameter int PRESC_W     = 6,
    parameter int SEG_W       = 4,
    parameter int SJW_W       = 3,
    parameter int SEG_MAX     = 8,
    parameter int SJW_MAX     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx,
    input  logic [PRESC_W-1:0] presc,
    input  logic [SEG_W-1:0]   seg_prop,
    input  logic [SEG_W-1:0]   seg_ph1,
    input  logic [SEG_W-1:0]   seg_ph2,
    input  logic [SJW_W-1:0]   sjw,
    input  logic               hard_sync_en,
    output logic               rx_bit,
    output logic               sample_strobe,
    output logic               bit_start,
    output logic               cfg_err
);
    import cbt_pkg::*;

    localparam int QCNT_W = $clog2(2*SEG_MAX + SJW_MAX + 1);

    bt_state_e         state_q, nxt_state;
    logic [QCNT_W-1:0] qcnt_q, nxt_qcnt;
    logic [SJW_W-1:0]  ext_q, nxt_ext;
    logic [SJW_W-1:0]  shr_q, nxt_shr;
    logic              done_q, nxt_done;
    logic              enter_sync, do_sample;
    logic [QCNT_W-1:0] len1_c, len2_c, late_err;

    logic tick, rx_s, fall;
    logic edge_ok, hard, resync_ok, late, early, early_restart, restart;

    cbt_cfg_check #(
        .SEG_W(SEG_W), .SJW_W(SJW_W), .SEG_MAX(SEG_MAX), .SJW_MAX(SJW_MAX)
    ) u_cfg (
        .prop_i(seg_prop), .ph1_i(seg_ph1), .ph2_i(seg_ph2), .sjw_i(sjw),
        .err_o(cfg_err)
    );

    cbt_rx_edge #(.STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .rx_i(rx), .rx_s_o(rx_s), .fall_o(fall)
    );

    cbt_quantum_gen #(.PRESC_W(PRESC_W)) u_tq (
        .clk(clk), .rst(rst), .presc_i(presc),
        .restart_i(restart || cfg_err), .tick_o(tick)
    );

    // edge classification
    assign edge_ok   = fall && !cfg_err;
    assign hard      = edge_ok && hard_sync_en && (state_q != ST_HALT);
    assign resync_ok = edge_ok && !hard_sync_en && !done_q
                    && ((state_q == ST_SEG1) || (state_q == ST_SEG2));
    assign late      = resync_ok && (state_q == ST_SEG1);
    assign early     = resync_ok && (state_q == ST_SEG2);
    assign early_restart = early
                    && ((qcnt_q + QCNT_W'(sjw)) >= QCNT_W'(seg_ph2));
    assign restart   = hard || early_restart;
    assign late_err  = qcnt_q + 1'b1;

    // next-state logic
    always_comb begin
        nxt_state  = state_q;
        nxt_qcnt   = qcnt_q;
        nxt_ext    = ext_q;
        nxt_shr    = shr_q;
        nxt_done   = done_q;
        enter_sync = 1'b0;
        do_sample  = 1'b0;
        len1_c     = '0;
        len2_c     = '0;
        unique case (state_q)
            ST_HALT: begin
                if (!cfg_err) begin
                    nxt_state  = ST_SYNC;
                    enter_sync = 1'b1;
                end
            end
            ST_SYNC: begin
                if (tick) begin
                    nxt_state = ST_SEG1;
                    nxt_qcnt  = '0;
                end
            end
            ST_SEG1: begin
                if (late) begin
                    nxt_done = 1'b1;
                    nxt_ext  = (late_err >= QCNT_W'(sjw)) ? sjw : SJW_W'(late_err);
                end
                len1_c = QCNT_W'(seg_prop) + QCNT_W'(seg_ph1) + QCNT_W'(nxt_ext);
                if (tick) begin
                    if ((qcnt_q + 1'b1) >= len1_c) begin
                        nxt_state = ST_SEG2;
                        nxt_qcnt  = '0;
                        do_sample = 1'b1;
                    end else begin
                        nxt_qcnt = qcnt_q + 1'b1;
                    end
                end
            end
            ST_SEG2: begin
                if (early && !early_restart) begin
                    nxt_done = 1'b1;
                    nxt_shr  = sjw;
                end
                len2_c = QCNT_W'(seg_ph2) - QCNT_W'(nxt_shr);
                if (tick) begin
                    if ((qcnt_q + 1'b1) >= len2_c) begin
                        nxt_state  = ST_SYNC;
                        nxt_qcnt   = '0;
                        nxt_ext    = '0;
                        nxt_shr    = '0;
                        nxt_done   = 1'b0;
                        enter_sync = 1'b1;
                    end else begin
                        nxt_qcnt = qcnt_q + 1'b1;
                    end
                end
            end
        endcase
        if (restart) begin
            nxt_state  = ST_SYNC;
            nxt_qcnt   = '0;
            nxt_ext    = '0;
            nxt_shr    = '0;
            nxt_done   = 1'b0;
            enter_sync = 1'b1;
            do_sample  = 1'b0;
        end
        if (cfg_err) begin
            nxt_state  = ST_HALT;
            nxt_qcnt   = '0;
            nxt_ext    = '0;
            nxt_shr    = '0;
            nxt_done   = 1'b0;
            enter_sync = 1'b0;
            do_sample  = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SYNC;
            qcnt_q  <= '0;
            ext_q   <= '0;
            shr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= nxt_state;
            qcnt_q  <= nxt_qcnt;
            ext_q   <= nxt_ext;
            shr_q   <= nxt_shr;
            done_q  <= nxt_done;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_start     <= 1'b0;
            sample_strobe <= 1'b0;
            rx_bit        <= 1'b1;
        end else begin
            bit_start     <= enter_sync;
            sample_strobe <= do_sample;
            if (do_sample) begin
                rx_bit <= rx_s;
            end
        end
    end

    AST_STROBES_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        !(bit_start && sample_strobe)); // R2
    AST_RXBIT_AT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_bit) |-> sample_strobe); // R2
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> !(bit_start || sample_strobe)); // R3
    AST_EXT_CAPPED: assert property (@(posedge clk) disable iff (rst)
        !cfg_err |-> (ext_q <= sjw)); // R4
    AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (rst)
        done_q |=> (done_q || bit_start || (state_q == ST_HALT))); // R7

endmodule

// File: tb/cbt_bit_timer_tb.sv
`timescale 1ns/1ps
module cbt_bit_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic [5:0] presc = 6'd3;
    logic [3:0] seg_prop = 4'd2, seg_ph1 = 4'd7, seg_ph2 = 4'd6;
    logic [2:0] sjw = 3'd4;
    logic       hard_sync_en = 1'b0;
    logic       rx_bit, sample_strobe, bit_start, cfg_err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    cbt_bit_timer u_dut (
        .clk(clk), .rst(rst), .rx(rx), .presc(presc),
        .seg_prop(seg_prop), .seg_ph1(seg_ph1), .seg_ph2(seg_ph2), .sjw(sjw),
        .hard_sync_en(hard_sync_en), .rx_bit(rx_bit),
        .sample_strobe(sample_strobe), .bit_start(bit_start), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [5:0] pr;
        logic [3:0] pp;
        logic [3:0] p1;
        logic [3:0] p2;
        logic [2:0] jw;
        logic       err;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{6'd0, 4'd2, 4'd7, 4'd6, 3'd4, 1'b0},
        '{6'd3, 4'd2, 4'd7, 4'd6, 3'd1, 1'b0},
        '{6'd1, 4'd1, 4'd1, 4'd1, 3'd1, 1'b0},
        '{6'd0, 4'd8, 4'd8, 4'd8, 3'd4, 1'b0},
        '{6'd0, 4'd1, 4'd2, 4'd4, 3'd1, 1'b1},
        '{6'd0, 4'd2, 4'd7, 4'd2, 3'd3, 1'b1},
        '{6'd0, 4'd0, 4'd7, 4'd6, 3'd1, 1'b1},
        '{6'd0, 4'd2, 4'd7, 4'd6, 3'd5, 1'b1},
        '{6'd0, 4'd2, 4'd9, 4'd6, 3'd1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // waits for a bit_start, then counts negedges to the next one;
    // rx is driven to the given values at the given counts
    task automatic run_bit(input int d1, input logic v1, input int d2, input logic v2,
                           input int d3, input logic v3,
                           output int per, output int samp, output logic sbit);
        int cnt = 0;
        int guard = 0;
        per = -1; samp = -1; sbit = 1'bx;
        @(negedge clk);
        while (!bit_start && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        while (per < 0 && cnt < 5000) begin
            @(negedge clk);
            cnt++;
            if (sample_strobe && samp < 0) begin
                samp = cnt;
                sbit = rx_bit;
            end
            if (bit_start) per = cnt;
            if (cnt == d1) rx = v1;
            if (cnt == d2) rx = v2;
            if (cnt == d3) rx = v3;
        end
    endtask

    task automatic set_base(input logic [2:0] jw);
        presc = 6'd3; seg_prop = 4'd2; seg_ph1 = 4'd7; seg_ph2 = 4'd6; sjw = jw;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int per, samp, q, strobes;
        logic sbit;

        // reset state, R10
        repeat (4) @(negedge clk);
        chk(bit_start == 1'b0, "R10 bit_start", int'(bit_start), 0);
        chk(sample_strobe == 1'b0, "R10 sample_strobe", int'(sample_strobe), 0);
        chk(rx_bit == 1'b1, "R10 rx_bit", int'(rx_bit), 1);
        chk(cfg_err == 1'b0, "R10 cfg_err", int'(cfg_err), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_bit == 1'b1 && !sample_strobe, "R10 after release", int'(rx_bit), 1);

        // table walk: R1, R2, R3
        for (int i = 0; i < NVEC; i++) begin
            presc = VECS[i].pr; seg_prop = VECS[i].pp; seg_ph1 = VECS[i].p1;
            seg_ph2 = VECS[i].p2; sjw = VECS[i].jw;
            @(negedge clk);
            chk(cfg_err == VECS[i].err, "R3 cfg_err", int'(cfg_err), int'(VECS[i].err));
            if (VECS[i].err) begin
                strobes = 0;
                for (int k = 0; k < 300; k++) begin
                    @(negedge clk);
                    if (bit_start || sample_strobe) strobes++;
                end
                chk(strobes == 0, "R3 strobes while halted", strobes, 0);
            end else begin
                q = 2 * (int'(VECS[i].pr) + 1);
                run_bit(-1, 1'b1, -1, 1'b1, -1, 1'b1, per, samp, sbit);
                run_bit(-1, 1'b1, -1, 1'b1, -1, 1'b1, per, samp, sbit);
                chk(per == q * (1 + VECS[i].pp + VECS[i].p1 + VECS[i].p2),
                    "R1 bit period", per, q * (1 + VECS[i].pp + VECS[i].p1 + VECS[i].p2));
                chk(samp == q * (1 + VECS[i].pp + VECS[i].p1),
                    "R2 sample offset", samp, q * (1 + VECS[i].pp + VECS[i].p1));
                chk(sbit == 1'b1, "R2 sampled recessive", int'(sbit), 1);
            end
        end

        // directed: quantum = 8 clocks, 1+2+7+6 quanta
        // an rx change at count 8*q+1 lands in quantum q
        set_base(3'd4);
        run_bit(-1, 1'b1, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        run_bit(25, 1'b0, 120, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 152, "R4 late edge q3 sjw4 period", per, 152);
        chk(samp == 104, "R4 late edge moves sample", samp, 104);
        rx = 1'b1;

        set_base(3'd2);
        run_bit(57, 1'b0, 120, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 144, "R4 late edge capped by sjw", per, 144);
        rx = 1'b1;

        set_base(3'd4);
        run_bit(9, 1'b0, 25, 1'b1, 41, 1'b0, per, samp, sbit);
        chk(per == 136, "R7 second edge ignored", per, 136);
        rx = 1'b1;

        run_bit(113, 1'b0, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 116, "R5 early edge restarts bit", per, 116);
        rx = 1'b1;

        run_bit(97, 1'b0, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 100, "R5 boundary k+sjw==ph2 restarts", per, 100);
        rx = 1'b1;

        run_bit(89, 1'b0, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 96, "R5 boundary shortens by sjw", per, 96);
        rx = 1'b1;

        set_base(3'd2);
        run_bit(97, 1'b0, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 112, "R5 phase2 cut sjw2", per, 112);
        rx = 1'b1;

        set_base(3'd4);
        run_bit(1, 1'b0, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 128, "R6 sync-quantum edge ignored", per, 128);
        chk(sbit == 1'b0, "R2 R6 sampled dominant", int'(sbit), 0);

        run_bit(25, 1'b1, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 128, "R8 rising edge ignored", per, 128);
        chk(sbit == 1'b1, "R8 sampled recessive", int'(sbit), 1);

        hard_sync_en = 1'b1;
        run_bit(41, 1'b0, -1, 1'b1, -1, 1'b1, per, samp, sbit);
        chk(per == 44, "R9 hard sync restart", per, 44);
        hard_sync_en = 1'b0;
        rx = 1'b1;

        // R3 recovery
        @(negedge clk);
        seg_ph2 = 4'd9;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R3 ph2 out of range", int'(cfg_err), 1);
        repeat (50) @(negedge clk);
        seg_ph2 = 4'd6;
        @(negedge clk);
        chk(bit_start == 1'b1, "R3 restart after recovery", int'(bit_start), 1);
        chk(cfg_err == 1'b0, "R3 cfg_err cleared", int'(cfg_err), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule